// File: doc/BRIEF.md
# Streaming SPI Master with Per-Word Target Select

This block is a serial peripheral interface master that receives parallel words on a valid/ready stream and shifts each one out on `mosi_o`, most significant bit first. While a word goes out, the block captures a word of the same width from `miso_i`. It presents that word on `rx_data_o` with a one-cycle strobe. The serial clock idles low. It is made from the system clock by a counter whose half period is `SYS_HZ / (2*SER_HZ)` system cycles. `SER_HZ` must be at most `SYS_HZ/10`, and `WORD_W` must be a power of two.

One active-low select line is driven for each attached target. The first word of a transfer carries the target address, which is latched when that word is accepted. Each word also carries an end-of-burst flag. When the flag is set, the select line is released after the word. When it is clear, the line stays low, the block waits with ready high, and the next word continues the same transfer to the same target.

A single state machine controls the block. Its states are IDLE, SHIFT, TAIL, GAP and GUARD.

- IDLE: every select line is high and ready is high. A handshake moves it to SHIFT.
- SHIFT: the block toggles the serial clock for one word. After the final falling edge it moves to TAIL when the flag was set, or to GAP when it was clear.
- TAIL: the select line is held for one half period after the last edge, then the block moves to GUARD.
- GUARD: the select line is high for one half period with ready low, then the block moves to IDLE.
- GAP: the select line is held with ready high and the clock low. A handshake moves it back to SHIFT.

Top module: `spi_stream_master`

## Requirements
- R1: After a synchronous reset, and in the cycle after any reset, every bit of `cs_n_o` is 1, `sclk_o` is 0, `tx_ready_o` is 1 and `rx_valid_o` is 0.
- R2: A word is taken only on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. Ready is low from acceptance until the block reaches GAP or IDLE, and a valid that arrives while ready is low starts nothing.
- R3: `sclk_o` idles low. Its first rising edge comes HALF = SYS_HZ/(2*SER_HZ) system cycles after the accepting edge. Each high phase and each low phase within a word lasts HALF cycles, so a word holds the clock high for WORD_W*HALF cycles.
- R4: `mosi_o` carries the word most significant bit first. It changes only while `sclk_o` is low and is stable while `sclk_o` is high (clock idle low, sample on rise).
- R5: `miso_i` is sampled at each rising edge, with the first sample becoming the most significant bit. The assembled word appears on `rx_data_o` while `rx_valid_o` is high for exactly one cycle, the cycle right after the final rising edge.
- R6: Line i of `cs_n_o` (bit i) is the only line driven low during a transfer to target address i. At most one line is low at any time.
- R7: With the end-of-burst flag set, the select line rises 2*HALF cycles after the strobe cycle, and ready returns HALF cycles after that.
- R8: With the flag clear, ready returns HALF cycles after the strobe cycle. The select line stays low and the clock stays low for as long as no new word is offered.
- R9: The address on words after the first of a burst is ignored. The latched target stays selected until the select line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | N_TGT | Active-low select, one line per target |
| mosi_o | output | 1 | Serial data to the target |
| miso_i | input | 1 | Serial data from the target |
| tx_addr_i | input | ADDR_W | Target address, used on the first word of a burst |
| tx_data_i | input | WORD_W | Word to send |
| tx_last_i | input | 1 | End-of-burst flag for this word |
| tx_valid_i | input | 1 | Input word is valid |
| tx_ready_o | output | 1 | Block can take a word |
| rx_data_o | output | WORD_W | Word received from the target |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |

## Verification
A state machine stuck in the wrong state shows up within one half period. Either the serial clock stops toggling while a select line is low, or ready is high while the clock is high. A bit counter that is off by one shows up at the end of the word: the clock pulse count, the shifted word or the strobe cycle is wrong, measured against the accepting edge. A lost or overwritten address latch moves the low select line in the middle of a burst, and this is caught in the very cycle it happens.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SHIFT = 3'd1,
        ST_TAIL  = 3'd2,
        ST_GAP   = 3'd3,
        ST_GUARD = 3'd4
    } spi_state_e;

endpackage

// File: rtl/spi_half_div.sv
module spi_half_div #(
    parameter int HALF = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] TOP = DIV_W'(HALF - 1);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == TOP) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == TOP);

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              sample,
    input  logic              final_s,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;
    logic [WORD_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
        end else if (shift) begin
            tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q  <= '0;
            out_q <= '0;
        end else begin
            if (sample) begin
                rx_q <= {rx_q[WORD_W-2:0], miso};
            end
            if (final_s) begin
                out_q <= {rx_q[WORD_W-2:0], miso};
            end
        end
    end

    assign mosi    = tx_q[WORD_W-1];
    assign rx_word = out_q;

endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
    parameter int N_TGT  = 1,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              active_d,
    output logic [N_TGT-1:0]  cs_n
);
    logic [ADDR_W-1:0] sel_q;
    logic [ADDR_W-1:0] sel_d;

    assign sel_d = latch ? addr_i : sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    for (genvar i = 0; i < N_TGT; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                cs_n[i] <= 1'b1;
            end else begin
                cs_n[i] <= !(active_d && (sel_d == ADDR_W'(i)));
            end
        end
    end

endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master
    import spi_stream_pkg::*;
#(
    parameter int SYS_HZ = 50_000_000,
    parameter int SER_HZ = 5_000_000,
    parameter int WORD_W = 8,
    parameter int N_TGT  = 1,
    parameter int ADDR_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic              sclk_o,
    output logic [N_TGT-1:0]  cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic [ADDR_W-1:0] tx_addr_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_last_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_valid_o
);
    localparam int HALF  = SYS_HZ / (2 * SER_HZ);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W);

    spi_state_e       state_q;
    spi_state_e       state_d;
    logic             tick;
    logic             div_en;
    logic             rdy;
    logic             accept;
    logic             sample;
    logic             shift;
    logic             final_s;
    logic             sclk_q;
    logic             last_q;
    logic             vld_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic             active_d;
    logic             latch_addr;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tick && sclk_q && (bit_cnt_q == LAST_BIT)) begin
                    state_d = last_q ? ST_TAIL : ST_GAP;
                end
            end
            ST_TAIL: begin
                if (tick) state_d = ST_GUARD;
            end
            ST_GUARD: begin
                if (tick) state_d = ST_IDLE;
            end
            ST_GAP: begin
                if (accept) state_d = ST_SHIFT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // per-state outputs and strobes
    always_comb begin
        rdy     = 1'b0;
        div_en  = 1'b0;
        sample  = 1'b0;
        shift   = 1'b0;
        final_s = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GAP: begin
                rdy = 1'b1;
            end
            ST_SHIFT: begin
                div_en  = 1'b1;
                sample  = tick && !sclk_q;
                final_s = tick && !sclk_q && (bit_cnt_q == LAST_BIT - 1'b1);
                shift   = tick && sclk_q && (bit_cnt_q != LAST_BIT);
            end
            ST_TAIL, ST_GUARD: begin
                div_en = 1'b1;
            end
            default: ;
        endcase
    end

    assign accept     = tx_valid_i && rdy;
    assign latch_addr = accept && (state_q == ST_IDLE);
    assign active_d   = (state_d == ST_SHIFT) || (state_d == ST_TAIL) || (state_d == ST_GAP);

    // serial clock, bit count, burst flag, strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            bit_cnt_q <= '0;
            last_q    <= 1'b0;
            vld_q     <= 1'b0;
        end else begin
            vld_q <= final_s;
            if (accept) begin
                last_q    <= tx_last_i;
                bit_cnt_q <= '0;
            end
            if (sample) begin
                sclk_q    <= 1'b1;
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if ((state_q == ST_SHIFT) && tick && sclk_q) begin
                sclk_q <= 1'b0;
            end
        end
    end

    spi_half_div #(
        .HALF (HALF)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (div_en),
        .tick (tick)
    );

    spi_word_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word (tx_data_i),
        .shift     (shift),
        .sample    (sample),
        .final_s   (final_s),
        .miso      (miso_i),
        .mosi      (mosi_o),
        .rx_word   (rx_data_o)
    );

    spi_cs_decode #(
        .N_TGT  (N_TGT),
        .ADDR_W (ADDR_W)
    ) u_cs (
        .clk      (clk),
        .rst      (rst),
        .latch    (latch_addr),
        .addr_i   (tx_addr_i),
        .active_d (active_d),
        .cs_n     (cs_n_o)
    );

    assign sclk_o     = sclk_q;
    assign tx_ready_o = rdy;
    assign rx_valid_o = vld_q;

endmodule

// File: rtl/spi_stream_master_chk.sv
module spi_stream_master_chk #(
    parameter int N_TGT = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             sclk,
    input logic [N_TGT-1:0] cs_n,
    input logic             mosi,
    input logic             rdy,
    input logic             vld
);
    // R1: the cycle after a reset edge shows the idle state
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> ((&cs_n) && !sclk && rdy && !vld));

    // R2: no handshake while the clock is high
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !rdy);

    // R3: the serial clock only runs with a select line low
    a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
        (&cs_n) |-> !sclk);

    // R4: data held through the high phase
    a_r4_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R5: receive strobe lasts one cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R6: at most one target selected
    a_r6_one_line: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R9: the selected line never moves while a transfer stays open
    a_r9_target_kept: assert property (@(posedge clk) disable iff (rst)
        (!(&cs_n) && !(&$past(cs_n))) |-> (cs_n == $past(cs_n)));

endmodule

bind spi_stream_master spi_stream_master_chk #(
    .N_TGT (N_TGT)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk_o),
    .cs_n (cs_n_o),
    .mosi (mosi_o),
    .rdy  (tx_ready_o),
    .vld  (rx_valid_o)
);

// File: tb/spi_stream_master_bench.sv
`timescale 1ns/1ps
module spi_stream_master_bench;
    localparam int SYS  = 40;
    localparam int SER  = 4;
    localparam int W    = 8;
    localparam int NT   = 4;
    localparam int AW   = 2;
    localparam int HALF = SYS / (2 * SER);

    // row = {addr(4), expected target(4), tx word(8), miso word(8), last(4)}
    localparam logic [27:0] VECS [6] = '{
        28'h0_0_A5_3C_1,
        28'h2_2_00_FF_1,
        28'h1_1_81_7E_0,
        28'h3_1_FF_00_0,
        28'h0_1_5A_C3_1,
        28'h3_3_01_80_1
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sclk;
    logic [NT-1:0] cs_n;
    logic          mosi;
    logic          miso;
    logic [AW-1:0] addr_i = '0;
    logic [W-1:0]  data_i = '0;
    logic          last_i = 1'b0;
    logic          valid_i = 1'b0;
    logic          rdy;
    logic [W-1:0]  rx_data;
    logic          rx_vld;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    spi_stream_master #(
        .SYS_HZ (SYS),
        .SER_HZ (SER),
        .WORD_W (W),
        .N_TGT  (NT),
        .ADDR_W (AW)
    ) u_spi_stream_master (
        .clk        (clk),
        .rst        (rst),
        .sclk_o     (sclk),
        .cs_n_o     (cs_n),
        .mosi_o     (mosi),
        .miso_i     (miso),
        .tx_addr_i  (addr_i),
        .tx_data_i  (data_i),
        .tx_last_i  (last_i),
        .tx_valid_i (valid_i),
        .tx_ready_o (rdy),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_vld)
    );

    // target model: captures MOSI on rises, advances MISO on falls
    logic [W-1:0] miso_sh  = '0;
    logic [W-1:0] mosi_cap = '0;
    int           rises    = 0;
    int           hi_cnt   = 0;
    logic         sclk_prev = 1'b0;

    always @(negedge clk) begin
        if (sclk) hi_cnt = hi_cnt + 1;
        if (sclk && !sclk_prev) begin
            mosi_cap = {mosi_cap[W-2:0], mosi};
            rises    = rises + 1;
        end
        if (!sclk && sclk_prev) miso_sh = {miso_sh[W-2:0], 1'b0};
        sclk_prev = sclk;
    end

    assign miso = miso_sh[W-1];

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [27:0] row, input bit poke);
        logic [AW-1:0] a;
        logic [3:0]    tgt;
        logic [W-1:0]  d;
        logic [W-1:0]  m;
        logic          l;
        logic [NT-1:0] exp_cs;
        int            n;
        a      = row[25:24];
        tgt    = row[23:20];
        d      = row[19:12];
        m      = row[11:4];
        l      = row[0];
        exp_cs = ~(NT'(1) << tgt);
        @(negedge clk);
        while (!rdy) @(negedge clk);
        #1;
        miso_sh  = m;
        mosi_cap = '0;
        rises    = 0;
        hi_cnt   = 0;
        addr_i   = a;
        data_i   = d;
        last_i   = l;
        valid_i  = 1'b1;
        @(posedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) valid_i = 1'b0;
        end while (!sclk);
        chk("R3 first rising edge delay", n, HALF + 1);
        if (poke) begin
            // R2: valid offered while busy must not be taken
            valid_i = 1'b1;
            data_i  = ~d;
            addr_i  = ~a;
            repeat (6) @(negedge clk);
            valid_i = 1'b0;
        end
        while (!rx_vld) @(negedge clk);
        chk("R5 received word", int'(rx_data), int'(m));
        chk("R6 selected line", int'(cs_n), int'(exp_cs));
        chk("R2 ready low while shifting", int'(rdy), 0);
        @(negedge clk);
        chk("R5 strobe width", int'(rx_vld), 0);
        n = 1;
        if (l) begin
            while (!(&cs_n)) begin
                @(negedge clk);
                n++;
            end
            chk("R7 select release delay", n, 2 * HALF);
            chk("R7 ready low in guard", int'(rdy), 0);
            while (!rdy) begin
                @(negedge clk);
                n++;
            end
            chk("R7 ready return delay", n, 3 * HALF);
        end else begin
            while (!rdy) begin
                @(negedge clk);
                n++;
            end
            chk("R8 ready return delay", n, HALF);
            chk("R8 line held in gap", int'(cs_n), int'(exp_cs));
        end
        chk("R4 word on MOSI", int'(mosi_cap), int'(d));
        chk("R3 clock pulses", rises, W);
        chk("R3 high time per word", hi_cnt, W * HALF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset select lines", int'(cs_n), 4'hF);
        chk("R1 reset sclk", int'(sclk), 0);
        chk("R1 reset ready", int'(rdy), 1);
        chk("R1 reset strobe", int'(rx_vld), 0);

        // table walk: single words, bursts, ignored burst addresses (R9)
        for (int i = 0; i < 6; i++) begin
            send(VECS[i], 1'b0);
        end

        // R8: open burst waits with clock low and line held
        send(28'h2_2_3C_A5_0, 1'b0);
        repeat (20) @(negedge clk);
        chk("R8 clock idle in gap", int'(sclk), 0);
        chk("R8 line held while waiting", int'(cs_n), 4'hB);
        chk("R8 ready while waiting", int'(rdy), 1);
        send(28'h0_2_E7_18_1, 1'b0);

        // R2: valid while busy is ignored, nothing starts after the word
        send(28'h2_2_C6_39_1, 1'b1);
        repeat (20) @(negedge clk);
        chk("R2 no extra transfer clock", hi_cnt, W * HALF);
        chk("R2 no extra transfer select", int'(cs_n), 4'hF);

        // R1: reset in the middle of a word
        @(negedge clk);
        #1;
        miso_sh = 8'hFF;
        addr_i  = 2'd1;
        data_i  = 8'h77;
        last_i  = 1'b0;
        valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
        while (!sclk) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-word reset select", int'(cs_n), 4'hF);
        chk("R1 mid-word reset sclk", int'(sclk), 0);
        chk("R1 mid-word reset ready", int'(rdy), 1);
        rst = 1'b0;
        send(28'h1_1_96_69_1, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule